// File: doc/BRIEF.md
# Daisy-Chain Packet Readout Concentrator

This block gathers fixed-size readout packets on one chip of a daisy chain and sends them as a single serial stream toward the next chip. Three local sources each write entries into their own small FIFO: regional-readout clusters, full-readout clusters and register/status readback. A fourth FIFO holds packets that arrive serially from the neighbouring chip and only pass through this one. Each local entry holds a 4-bit packet type and a 49-bit payload.

When the transmitter is idle and downstream has not asserted XOFF, the block selects the highest-priority non-empty source. The order of the sources comes from a priority input. For a local packet, the block builds a 59-bit frame by adding a start bit, this chip's ID and a trailing marker bit, then shifts the frame out MSB first. A pass-through packet is sent again bit for bit, so the chip ID of the chip that produced it is kept. A packet that has started is never interrupted. When the pass-through FIFO is close to full, the block raises its own XOFF toward the upstream chip.

Top module: `rdo_concentrator`

## Requirements
- R1: After reset, `ser_o`, `xoff_o` and every bit of `loc_full_o` are 0.
- R2: A transmitted frame is 59 bits, sent MSB first, one bit per clock: a 1 start bit, the 4-bit type, the 4-bit chip ID, the 49-bit payload, then a 1 marker bit. Between frames the line is 0 for at least one cycle.
- R3: For local packets, the chip ID field is taken from `chip_id_i`. Type is data bits [52:49] and payload is bits [48:0] of the written entry.
- R4: With `prio_i` = 8'hE4, the order from highest to lowest is pass-through, regional, full readout, register readback.
- R5: `prio_i` holds four 2-bit source codes, with bits [1:0] as the highest slot. The codes are 0 for pass-through, 1 for regional, 2 for full readout and 3 for readback. The first slot whose source is non-empty is served.
- R6: Arbitration takes place only when no frame is being sent. When `xoff_i` is 1 in the cycle a frame would start, that frame does not start. A frame already in progress always completes.
- R7: A 1 on an idle `ser_i` marks a header. The next 58 bits are stored in the pass-through FIFO and later sent unchanged after a new start bit.
- R8: `xoff_o` is 1 exactly when the pass-through FIFO holds 14 or more of its 16 entries.
- R9: A pass-through packet that arrives when the FIFO is full is dropped.
- R10: `loc_full_o[k]` is 1 when local FIFO k holds 4 entries. Here k=0 is regional, k=1 is full readout and k=2 is readback. A write to a full FIFO is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_id_i | input | 4 | This chip's ID |
| prio_i | input | 8 | Four 2-bit source codes, highest slot first |
| reg_wr_i | input | 1 | Write strobe, regional FIFO |
| reg_data_i | input | 53 | Type and payload, regional |
| full_wr_i | input | 1 | Write strobe, full-readout FIFO |
| full_data_i | input | 53 | Type and payload, full readout |
| rb_wr_i | input | 1 | Write strobe, readback FIFO |
| rb_data_i | input | 53 | Type and payload, readback |
| loc_full_o | output | 3 | Full flags of the local FIFOs |
| ser_i | input | 1 | Serial stream from the adjacent chip |
| xoff_o | output | 1 | Flow control toward upstream |
| xoff_i | input | 1 | Flow control from downstream |
| ser_o | output | 1 | Serial stream toward the next chip |

## Verification
- A local write at clock edge E is visible to the arbiter after E. A frame can start at E+1, and its start bit appears on `ser_o` after that edge.
- The last bit of an incoming packet sampled at edge E reaches the pass-through FIFO at E+1. It can change `xoff_o` just after that edge and can be chosen for transmission at E+2.
- The reference model in the bench follows this edge order: arbitration on the counts before the edge, then stores. The bench compares `ser_o`, `xoff_o` and `loc_full_o` at every falling edge.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int TYPE_W  = 4;
  localparam int ID_W    = 4;
  localparam int PAY_W   = 49;
  localparam int LOC_W   = TYPE_W + PAY_W;
  localparam int FRAME_W = 1 + TYPE_W + ID_W + PAY_W + 1;
  localparam int THRU_W  = FRAME_W - 1;
  localparam int N_SRC   = 4;
  localparam int SRC_W   = 2;
  typedef enum logic [SRC_W-1:0] {
    SRC_THRU = 2'd0, SRC_REG = 2'd1, SRC_FULL = 2'd2, SRC_RB = 2'd3
  } src_e;
endpackage

// File: rtl/rdo_fifo.sv
module rdo_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rd_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          wr_en, rd_en;

  assign empty_o = (cnt_o == '0);
  assign full_o  = (cnt_o == CW'(DEPTH));
  assign wr_en   = wr_i && !full_o;
  assign rd_en   = rd_i && !empty_o;
  assign rdata_o = mem[rp];

  always_ff @(posedge clk_i) if (wr_en) mem[wp] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp <= '0; rp <= '0; cnt_o <= '0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rdo_rx.sv
module rdo_rx #(
  parameter int N  = 58,
  localparam int CW = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  output logic         done_o,
  output logic [N-1:0] data_o
);
  localparam logic [CW-1:0] LAST = CW'(N-1);
  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0; cnt <= '0; data_o <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy) begin
        data_o <= {data_o[N-2:0], ser_i};
        cnt    <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end
      end else if (ser_i) begin
        busy <= 1'b1;   // header seen on idle line
        cnt  <= '0;
      end
    end
  end
endmodule

// File: rtl/rdo_tx.sv
module rdo_tx
  import rdo_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   xoff_i,
  input  logic [ID_W-1:0]        chip_id_i,
  input  logic [2*N_SRC-1:0]     prio_i,
  input  logic [N_SRC-1:0]       avail_i,
  input  logic [THRU_W-1:0]      thru_head_i,
  input  logic [LOC_W-1:0]       reg_head_i,
  input  logic [LOC_W-1:0]       full_head_i,
  input  logic [LOC_W-1:0]       rb_head_i,
  output logic [N_SRC-1:0]       pop_o,
  output logic                   busy_o,
  output logic                   ser_o
);
  localparam int CW = $clog2(FRAME_W);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W-1);

  logic [SRC_W-1:0]   sel;
  logic               found, start;
  logic [LOC_W-1:0]   loc_head;
  logic [FRAME_W-1:0] frame, sr;
  logic [CW-1:0]      cnt;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int s = 0; s < N_SRC; s++) begin
      if (!found && avail_i[prio_i[SRC_W*s +: SRC_W]]) begin
        found = 1'b1;
        sel   = prio_i[SRC_W*s +: SRC_W];
      end
    end
  end

  always_comb begin
    case (src_e'(sel))
      SRC_REG:  loc_head = reg_head_i;
      SRC_FULL: loc_head = full_head_i;
      default:  loc_head = rb_head_i;
    endcase
    if (src_e'(sel) == SRC_THRU) frame = {1'b1, thru_head_i};
    else frame = {1'b1, loc_head[LOC_W-1 -: TYPE_W], chip_id_i, loc_head[PAY_W-1:0], 1'b1};
  end

  assign start  = !busy_o && !xoff_i && found;
  assign pop_o  = start ? (N_SRC'(1) << sel) : '0;
  assign ser_o  = busy_o & sr[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr <= '0; cnt <= '0; busy_o <= 1'b0;
    end else if (start) begin
      sr <= frame; cnt <= '0; busy_o <= 1'b1;
    end else if (busy_o) begin
      sr <= {sr[FRAME_W-2:0], 1'b0};
      if (cnt == LAST) busy_o <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rdo_concentrator.sv
module rdo_concentrator
  import rdo_pkg::*;
#(
  parameter int LOC_DEPTH  = 4,
  parameter int THRU_DEPTH = 16,
  parameter int XOFF_FREE  = 2,
  localparam int LCW = $clog2(LOC_DEPTH + 1),
  localparam int TCW = $clog2(THRU_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       chip_id_i,
  input  logic [7:0]       prio_i,
  input  logic             reg_wr_i,
  input  logic [52:0]      reg_data_i,
  input  logic             full_wr_i,
  input  logic [52:0]      full_data_i,
  input  logic             rb_wr_i,
  input  logic [52:0]      rb_data_i,
  output logic [2:0]       loc_full_o,
  input  logic             ser_i,
  output logic             xoff_o,
  input  logic             xoff_i,
  output logic             ser_o
);
  localparam int N_LOC = N_SRC - 1;
  localparam logic [TCW-1:0] XOFF_LVL = TCW'(THRU_DEPTH - XOFF_FREE);

  logic [N_LOC-1:0] loc_wr, loc_empty;
  logic [LOC_W-1:0] loc_wdata [N_LOC];
  logic [LOC_W-1:0] loc_head  [N_LOC];
  logic [N_SRC-1:0] pop;
  logic             rx_done, thru_empty, thru_full, tx_busy;
  logic [THRU_W-1:0] rx_data, thru_head;
  logic [TCW-1:0]   thru_cnt;

  assign loc_wr       = {rb_wr_i, full_wr_i, reg_wr_i};
  assign loc_wdata[0] = reg_data_i;
  assign loc_wdata[1] = full_data_i;
  assign loc_wdata[2] = rb_data_i;

  for (genvar k = 0; k < N_LOC; k++) begin : g_loc
    logic [LCW-1:0] cnt_unused;
    rdo_fifo #(.W(LOC_W), .DEPTH(LOC_DEPTH)) u_fifo (
      .clk_i, .rst_ni,
      .wr_i(loc_wr[k]), .wdata_i(loc_wdata[k]),
      .rd_i(pop[k+1]), .rdata_o(loc_head[k]),
      .empty_o(loc_empty[k]), .full_o(loc_full_o[k]), .cnt_o(cnt_unused)
    );
  end

  rdo_rx #(.N(THRU_W)) u_rx (
    .clk_i, .rst_ni, .ser_i, .done_o(rx_done), .data_o(rx_data)
  );

  rdo_fifo #(.W(THRU_W), .DEPTH(THRU_DEPTH)) u_thru (
    .clk_i, .rst_ni,
    .wr_i(rx_done), .wdata_i(rx_data),
    .rd_i(pop[0]), .rdata_o(thru_head),
    .empty_o(thru_empty), .full_o(thru_full), .cnt_o(thru_cnt)
  );

  assign xoff_o = (thru_cnt >= XOFF_LVL);

  rdo_tx u_tx (
    .clk_i, .rst_ni, .xoff_i, .chip_id_i, .prio_i,
    .avail_i({~loc_empty, ~thru_empty}),
    .thru_head_i(thru_head),
    .reg_head_i(loc_head[0]), .full_head_i(loc_head[1]), .rb_head_i(loc_head[2]),
    .pop_o(pop), .busy_o(tx_busy), .ser_o
  );
endmodule

// File: rtl/rdo_concentrator_chk.sv
module rdo_concentrator_chk #(
  parameter int THRU_DEPTH = 16,
  localparam int TCW = $clog2(THRU_DEPTH + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           xoff_i,
  input logic           xoff_o,
  input logic           ser_o,
  input logic           tx_busy,
  input logic [3:0]     pop,
  input logic [TCW-1:0] thru_cnt
);
  a_r2_start_bit_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> ser_o);
  a_r2_idle_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_busy) |-> !ser_o);
  a_r6_no_start_in_xoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> !$past(xoff_i));
  a_r6_no_pop_mid_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy |-> pop == 4'b0);
  a_r4_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop));
  a_r9_thru_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thru_cnt <= TCW'(THRU_DEPTH));
  a_r8_xoff_rises_on_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xoff_o) |-> thru_cnt > $past(thru_cnt));
endmodule

bind rdo_concentrator rdo_concentrator_chk #(.THRU_DEPTH(THRU_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .xoff_i(xoff_i), .xoff_o(xoff_o),
  .ser_o(ser_o), .tx_busy(tx_busy), .pop(pop), .thru_cnt(thru_cnt)
);

// File: tb/rdo_concentrator_tb_top.sv
module rdo_concentrator_tb_top;
  localparam int CLK_P = 10;
  localparam int LOC_D = 4;
  localparam int THR_D = 16;

  logic clk_i = 0, rst_ni = 0;
  logic [3:0]  chip_id_i = 4'h5;
  logic [7:0]  prio_i = 8'hE4;
  logic        reg_wr_i = 0, full_wr_i = 0, rb_wr_i = 0;
  logic [52:0] reg_data_i = '0, full_data_i = '0, rb_data_i = '0;
  logic [2:0]  loc_full_o;
  logic        ser_i = 0, xoff_o, xoff_i = 0, ser_o;

  rdo_concentrator dut_i (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit done_flag = 0, cmp_en = 0;
  string cur_req = "R1";

  // reference model
  bit [52:0] q_loc [3][$];
  bit [57:0] q_thru [$];
  bit        m_busy, rx_busy, rx_pend;
  int        m_cnt, rx_cnt;
  bit [58:0] m_frame;
  bit [57:0] rx_bits;
  int        sz [4];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (q_loc[k]) q_loc[k].delete();
      q_thru.delete();
      m_busy = 0; rx_busy = 0; rx_pend = 0; m_cnt = 0; rx_cnt = 0;
    end else begin
      sz[0] = q_thru.size();
      for (int k = 0; k < 3; k++) sz[k+1] = q_loc[k].size();
      if (m_busy) begin
        if (m_cnt == 58) m_busy = 0; else m_cnt++;
      end else if (!xoff_i) begin
        for (int s = 0; s < 4; s++) begin
          int src;
          src = prio_i[2*s +: 2];
          if (sz[src] > 0) begin
            if (src == 0) m_frame = {1'b1, q_thru.pop_front()};
            else begin
              bit [52:0] d;
              d = q_loc[src-1].pop_front();
              m_frame = {1'b1, d[52:49], chip_id_i, d[48:0], 1'b1};
            end
            m_busy = 1; m_cnt = 0;
            break;
          end
        end
      end
      if (rx_pend) begin
        if (sz[0] < THR_D) q_thru.push_back(rx_bits);
        rx_pend = 0;
      end
      if (reg_wr_i  && sz[1] < LOC_D) q_loc[0].push_back(reg_data_i);
      if (full_wr_i && sz[2] < LOC_D) q_loc[1].push_back(full_data_i);
      if (rb_wr_i   && sz[3] < LOC_D) q_loc[2].push_back(rb_data_i);
      if (rx_busy) begin
        rx_bits = {rx_bits[56:0], ser_i};
        if (rx_cnt == 57) begin rx_busy = 0; rx_pend = 1; end
        else rx_cnt++;
      end else if (ser_i) begin
        rx_busy = 1; rx_cnt = 0;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (cmp_en && !done_flag) begin
    bit e_ser;
    e_ser = m_busy ? m_frame[58 - m_cnt] : 1'b0;
    chk(ser_o === e_ser, cur_req, "ser_o", ser_o, e_ser);
    chk(xoff_o === (q_thru.size() >= THR_D - 2), "R8", "xoff_o", xoff_o,
        q_thru.size() >= THR_D - 2);
    for (int k = 0; k < 3; k++)
      chk(loc_full_o[k] === (q_loc[k].size() == LOC_D), "R10", "loc_full_o",
          loc_full_o[k], q_loc[k].size() == LOC_D);
  end

  task automatic tick(int n); repeat (n) @(negedge clk_i); endtask

  task automatic wr_loc(int k, bit [52:0] d);
    case (k)
      0: begin reg_wr_i = 1; reg_data_i = d; end
      1: begin full_wr_i = 1; full_data_i = d; end
      default: begin rb_wr_i = 1; rb_data_i = d; end
    endcase
    @(negedge clk_i);
    reg_wr_i = 0; full_wr_i = 0; rb_wr_i = 0;
  endtask

  task automatic send_thru(bit [57:0] d);
    ser_i = 1;
    for (int i = 57; i >= 0; i--) begin @(negedge clk_i); ser_i = d[i]; end
    @(negedge clk_i); ser_i = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      if (!m_busy && !rx_busy && !rx_pend && q_thru.size() == 0 &&
          q_loc[0].size() == 0 && q_loc[1].size() == 0 && q_loc[2].size() == 0) break;
      @(negedge clk_i);
    end
    tick(3);
  endtask

  function automatic bit [57:0] thru_pkt(bit [3:0] t, bit [3:0] id, bit [48:0] p);
    return {t, id, p, 1'b1};
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P*150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(2);
    // R1: reset state
    chk(ser_o === 0, "R1", "ser_o", ser_o, 0);
    chk(xoff_o === 0, "R1", "xoff_o", xoff_o, 0);
    chk(loc_full_o === 3'b0, "R1", "loc_full_o", loc_full_o, 0);
    rst_ni = 1; cmp_en = 1;
    tick(3);

    // R2/R3: single frames, two chip IDs
    cur_req = "R2";
    wr_loc(0, {4'b0010, 49'h1_2345_6789_ABCD});
    drain();
    cur_req = "R3";
    chip_id_i = 4'hA;
    wr_loc(2, {4'b1000, 49'h0_0000_0F01});
    wr_loc(1, {4'b0110, 49'h1_FFFF_0000_5555});
    drain();

    // R4: default order with all sources pending
    cur_req = "R4";
    xoff_i = 1;
    wr_loc(2, {4'b1000, 49'h3});
    wr_loc(1, {4'b0110, 49'h2});
    wr_loc(0, {4'b0011, 49'h1});
    send_thru(thru_pkt(4'b0011, 4'h2, 49'h0_AAAA_5555_1234));
    tick(3);
    xoff_i = 0;
    drain();

    // R5: reversed priority
    cur_req = "R5";
    prio_i = 8'h1B;
    xoff_i = 1;
    wr_loc(0, {4'b0010, 49'h11});
    wr_loc(2, {4'b1000, 49'h33});
    send_thru(thru_pkt(4'b0110, 4'h7, 49'h77));
    wr_loc(1, {4'b0110, 49'h22});
    tick(2);
    xoff_i = 0;
    drain();
    prio_i = 8'hE4;

    // R6: xoff raised mid-frame lets frame finish, then blocks
    cur_req = "R6";
    wr_loc(0, {4'b0011, 49'h1_0F0F_0F0F_0F0F});
    wr_loc(1, {4'b0110, 49'h0_1234});
    tick(10);
    xoff_i = 1;
    tick(120);
    chk(ser_o === 0, "R6", "ser_o held idle", ser_o, 0);
    xoff_i = 0;
    drain();

    // R7: pass-through verbatim, back-to-back packets, foreign chip IDs
    cur_req = "R7";
    send_thru(thru_pkt(4'b1000, 4'h1, 49'h0_0000_0000_0005));
    send_thru(thru_pkt(4'b0010, 4'h3, 49'h1_5A5A_A5A5_5A5A));
    drain();

    // R8/R9: fill pass-through with 17 packets while blocked
    cur_req = "R9";
    xoff_i = 1;
    for (int i = 0; i < 17; i++) send_thru(thru_pkt(4'b0011, 4'(i), 49'(i * 3 + 1)));
    tick(3);
    chk(xoff_o === 1, "R8", "xoff_o when nearly full", xoff_o, 1);
    xoff_i = 0;
    drain();
    chk(xoff_o === 0, "R8", "xoff_o after drain", xoff_o, 0);

    // R10: local overflow drop
    cur_req = "R10";
    xoff_i = 1;
    for (int i = 0; i < 5; i++) wr_loc(0, {4'b0010, 49'(100 + i)});
    tick(2);
    chk(loc_full_o === 3'b001, "R10", "loc_full_o", loc_full_o, 3'b001);
    xoff_i = 0;
    drain();

    tick(5);
    finish_run();
  end
endmodule